// File: doc/BRIEF.md
# Direct-Mapped Single-Byte Read Cache

This block sits between a requester that reads single bytes and a slower main memory. It is a direct-mapped cache in which every line stores exactly one byte. A byte address therefore splits into two fields only: the low `IDX_W` bits choose the line, which is the address modulo the line count, and the remaining upper bits form the tag stored with that line. Each line keeps a valid flag, a tag and a data byte. Reset clears every valid flag, so the cache starts empty.

A request is accepted whenever the cache is not busy. If the selected line is valid and its tag equals the upper address bits, the stored byte is returned one cycle later. If not, the cache raises `busy` and stalls the requester. It then holds a read request with the full address on the memory port until memory answers, which may take any number of cycles. On that answer it overwrites the selected line and returns the byte in the same step, so no second lookup is needed. Only one miss is ever in flight. Writes are not part of this block.

Top module: `byte_dm_cache`

## Requirements
- R1: After reset, `rsp_valid`, `busy` and `mem_req` are 0 and `req_ready` is 1. Every line is invalid, so the first read of any address misses.
- R2: The line index is `req_addr[IDX_W-1:0]` and the tag is `req_addr[ADDR_W-1:IDX_W]`. Two addresses with the same index and different tags compete for the same line.
- R3: A read accepted at a clock edge that hits drives `rsp_valid`=1 after that edge, with the stored byte on `rsp_data`. It leaves `busy` and `mem_req` at 0.
- R4: On a miss, `busy`=1, `req_ready`=0 and `mem_req`=1 from the cycle after acceptance. `mem_addr` carries the full requested address.
- R5: While `mem_req` is 1 and `mem_valid` is 0, `mem_req` stays 1 and `mem_addr` stays unchanged, for any number of wait cycles.
- R6: At the edge where `mem_valid` is 1 while `mem_req` is 1, the line is filled. After that edge `rsp_valid`=1, `rsp_data` equals the `mem_data` that was sampled, and `busy` and `mem_req` are 0.
- R7: After a fill, reading the same address hits and returns the filled byte, even if main memory has changed since.
- R8: A miss overwrites only its mapped line. A byte previously cached there under another tag then misses, while other lines keep hitting.
- R9: `mem_valid` asserted while no miss is outstanding has no effect on the outputs or on the cached contents.
- R10: `req_valid` asserted while `busy` is 1 is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle pulse marking returned data |
| rsp_data | output | 8 | Returned byte |
| busy | output | 1 | Stall indication while a miss is outstanding |
| mem_req | output | 1 | Read request to main memory, held until answered |
| mem_addr | output | ADDR_W | Address sent to main memory |
| mem_valid | input | 1 | Main memory data present |
| mem_data | input | 8 | Byte returned by main memory |

## Verification
The bench builds the cache with `ADDR_W`=12 and `IDX_W`=4, giving 16 lines and an 8-bit tag. With so few lines, the bench can sweep every line from cold, and a random address stream drawn from a handful of tags forces frequent conflict replacements. Memory latency ranges from zero to several wait cycles, and the memory contents are changed between accesses. A hit can therefore be told apart from a refetch by the byte it returns.

// File: rtl/byte_dm_cache.sv
module byte_dm_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [7:0]        mem_data
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] line_vld;
  logic [TAG_W-1:0] tag_ram [LINES];
  logic [7:0]       dat_ram [LINES];

  logic              pend;
  logic [ADDR_W-1:0] pend_addr;

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] fl_idx;
  logic             accept;
  logic             lk_hit;
  logic             fill;

  assign lk_idx = req_addr[IDX_W-1:0];
  assign lk_tag = req_addr[ADDR_W-1:IDX_W];
  assign fl_idx = pend_addr[IDX_W-1:0];
  assign accept = req_valid && !pend;
  assign lk_hit = line_vld[lk_idx] && (tag_ram[lk_idx] == lk_tag);
  assign fill   = pend && mem_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)
      line_vld <= '0;
    else if (fill)
      line_vld[fl_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_ram[fl_idx] <= pend_addr[ADDR_W-1:IDX_W];
      dat_ram[fl_idx] <= mem_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (fill) begin
        pend      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= mem_data;
      end else if (accept) begin
        if (lk_hit) begin
          rsp_valid <= 1'b1;
          rsp_data  <= dat_ram[lk_idx];
        end else begin
          pend      <= 1'b1;
          pend_addr <= req_addr;
        end
      end
    end
  end

  assign req_ready = !pend;
  assign busy      = pend;
  assign mem_req   = pend;
  assign mem_addr  = pend_addr;
endmodule

// File: rtl/byte_dm_cache_chk.sv
module byte_dm_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data,
  input logic              busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic [7:0]        mem_data
);
  // R10
  stall_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R5
  wait_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R6
  fill_returns_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (rsp_valid && !busy && !mem_req && rsp_data == $past(mem_data)));

  // R4
  miss_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && $past(req_valid) && mem_addr == $past(req_addr)));

  // R9
  stray_data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && mem_valid && !req_valid) |=> (!rsp_valid && !busy));
endmodule

bind byte_dm_cache byte_dm_cache_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/byte_dm_cache_tb_top.sv
`timescale 1ns/1ps
module byte_dm_cache_tb_top;
  localparam int AW = 12;
  localparam int IW = 4;
  localparam int NL = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, busy, mem_req;
  logic [7:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic mem_valid;
  logic [7:0] mem_data;
  logic resp_v = 1'b0, stray_v = 1'b0;
  logic [7:0] resp_d = '0, stray_d = '0;

  assign mem_valid = resp_v | stray_v;
  assign mem_data  = stray_v ? stray_d : resp_d;

  always #2.5 clk = ~clk;

  byte_dm_cache #(.ADDR_W(AW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data));

  int checks = 0, errors = 0;
  logic [7:0] epoch = 8'h00;
  int lat = 0;
  logic [AW-1:0] exp_maddr = '0;
  logic [7:0] exp_q[$];
  logic       kind_q[$];
  logic m_vld [NL];
  logic [AW-IW-1:0] m_tag [NL];
  logic [7:0] m_dat [NL];

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return (a[7:0] ^ {a[11:8], 4'h5}) + epoch;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R10", 1, 0);
      else begin
        logic [7:0] e;
        logic k;
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        chk(rsp_data == e, k ? "R3" : "R6", rsp_data, e);
      end
    end
  end

  // memory responder
  initial begin
    int wcnt;
    logic [AW-1:0] held;
    wcnt = 0;
    held = '0;
    forever begin
      @(negedge clk);
      if (resp_v) begin
        resp_v = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt == 0) chk(mem_addr == exp_maddr, "R4", mem_addr, exp_maddr);
        else chk(mem_addr == held, "R5", mem_addr, held);
        held = mem_addr;
        if (wcnt == lat) begin
          resp_v = 1'b1;
          resp_d = mem_byte(mem_addr);
        end
        wcnt++;
      end
    end
  end

  task automatic access(logic [AW-1:0] a, int l, bit poke = 0, logic [AW-1:0] pa = '0);
    logic [IW-1:0] ix;
    bit hit;
    logic [7:0] e;
    ix = a[IW-1:0];
    hit = m_vld[ix] && m_tag[ix] == a[AW-1:IW];
    e = hit ? m_dat[ix] : mem_byte(a);
    if (!hit) begin
      m_vld[ix] = 1'b1;
      m_tag[ix] = a[AW-1:IW];
      m_dat[ix] = e;
    end
    @(negedge clk);
    lat = l;
    exp_maddr = a;
    exp_q.push_back(e);
    kind_q.push_back(hit);
    req_valid = 1'b1;
    req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      chk(!busy && !mem_req, "R3", busy, 0);
      chk(rsp_valid, "R3", rsp_valid, 1);
    end else begin
      chk(busy && !req_ready && mem_req, "R4", busy, 1);
      if (poke) begin
        req_valid = 1'b1;
        req_addr = pa;
        @(negedge clk);
        req_valid = 1'b0;
      end
      while (busy) @(negedge clk);
      chk(rsp_valid && !mem_req, "R6", rsp_valid, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < NL; i++) m_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !busy && !mem_req && req_ready, "R1", {rsp_valid, busy, mem_req, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !busy && !mem_req && req_ready, "R1", {rsp_valid, busy, mem_req, req_ready}, 1);

    // R1: cold sweep of every line
    for (int i = 0; i < NL; i++) access(AW'(i), i % 5);
    epoch = epoch + 8'h31;
    // R7: hits return cached bytes despite memory change
    for (int i = 0; i < NL; i++) access(AW'(i), 0);

    // R2, R8: conflict on line 3
    access(12'h053, 2);
    access(12'h004, 0);
    access(12'h003, 1);
    access(12'h053, 0);

    // R9: stray memory data while idle
    @(negedge clk);
    stray_d = 8'hEE;
    stray_v = 1'b1;
    @(negedge clk);
    stray_v = 1'b0;
    chk(!rsp_valid && !busy && !mem_req, "R9", {rsp_valid, busy, mem_req}, 0);
    access(12'h005, 0);

    // R10: request during stall is dropped
    access(12'h0A7, 4, 1, 12'h0C8);
    @(negedge clk);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
    access(12'h0C8, 1);

    // random stream with conflicts
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = {4'h0, 4'($urandom_range(0, 3)), 4'($urandom)};
      if ($urandom_range(0, 15) == 0) epoch = epoch + 8'h17;
      access(a, $urandom_range(0, 6));
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    summary();
  end
endmodule